// File: doc/BRIEF.md
# Accumulator ALU with Dual Flag Banks

This block is the eight-bit arithmetic and logic stage of a small accumulator machine. It takes the accumulator value, a second operand, an incoming carry and a three-bit operation code. In the same cycle it produces the result, a write strobe for the accumulator and the next value of the four condition flags. The operations are add, add with carry, subtract, subtract with borrow, compare, AND, OR and XOR. Upstream logic fetches the operands and decodes instructions. The accumulator register itself sits outside the block.

The flags are sign, zero, carry and one shared logical/overflow flag. That shared flag carries different information depending on the operation class:
- After an arithmetic operation it reports signed two's-complement overflow.
- After a logical operation it reports whether the upper half of the result holds any set bit.

Two flag registers live inside the block, a primary bank and an alternate bank. When the flag-write enable is high, a bank-select pin picks which of the two takes the new flags on the clock edge.

All data paths are combinational and complete within a single cycle. There is therefore no valid/ready pairing and no back-pressure: every operand set presented is consumed in the cycle it appears. The only sequential element is the flag bank, and its updates are gated by a plain enable.

Top module: `acc_alu`

## Requirements
- R1: With op code 000 (add), `res_o` is (acc + operand) mod 256 and the carry flag is the carry out of bit 7.
- R2: With op code 001 (add with carry), `res_o` is (acc + operand + `cin_i`) mod 256 and the carry flag is the carry out of bit 7.
- R3: Op code 010 (subtract) gives acc − operand, and op code 011 (subtract with borrow) gives acc − operand − `cin_i`, both mod 256. For both, the carry flag is 1 exactly when a borrow occurs.
- R4: Op code 111 (compare) produces the same flags as subtract and holds `acc_we_o` low. Every other op code drives `acc_we_o` high.
- R5: Op codes 100 (AND), 101 (XOR) and 110 (OR) give the bitwise result and clear the carry flag, whatever the value of `cin_i`.
- R6: After op codes 000 to 011 and 111, the logical/overflow flag is 1 exactly when the signed two's-complement result overflows.
- R7: After op codes 100 to 110, the logical/overflow flag is 1 exactly when any of result bits 7:4 is 1.
- R8: The sign flag equals result bit 7. The zero flag is 1 exactly when all eight result bits are 0. Flag vectors are packed as bit 3 sign, bit 2 zero, bit 1 logical/overflow, bit 0 carry.
- R9: On a rising clock edge with `flag_we_i` high, the primary bank takes `nflags_o` when `alt_sel_i` is 0, and the alternate bank takes it when `alt_sel_i` is 1. The other bank holds its value. With `flag_we_i` low, neither bank changes.
- R10: An active-low reset clears both flag banks to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flag banks update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| cin_i | input | 1 | Incoming carry, used by add with carry and subtract with borrow |
| op_i | input | 3 | Operation code |
| flag_we_i | input | 1 | Flag bank write enable |
| alt_sel_i | input | 1 | 0 selects the primary bank, 1 selects the alternate bank |
| res_o | output | 8 | Operation result |
| acc_we_o | output | 1 | Accumulator write strobe |
| nflags_o | output | 4 | Flags computed this cycle {sign, zero, logical/overflow, carry} |
| pri_flags_o | output | 4 | Primary flag bank |
| alt_flags_o | output | 4 | Alternate flag bank |

## Verification
Two things happen in the same cycle: the result and next flags are computed combinationally, and the previous selection is captured into one of the two banks. The bench issues operations back to back and toggles the bank select between them. Each cycle it therefore judges three things together: the fresh flags, the bank that was just written, and the bank that must have held its value. Compare operations, which update flags without writing the accumulator, are interleaved with alternate-bank writes. Some vectors are chosen so that carry and signed overflow arise together on the same add, to show that the shared flag and the carry flag do not interfere.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic sgn;
    logic zer;
    logic lv;
    logic cy;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);

  typedef struct packed {
    logic is_logic;
    logic do_sub;
    logic use_cin;
    logic wr_acc;
    logic [1:0] lsel;
  } dec_t;

  function automatic dec_t decode_op(alu_op_e op);
    dec_t d;
    d.is_logic = 1'b0;
    d.do_sub   = 1'b0;
    d.use_cin  = 1'b0;
    d.wr_acc   = 1'b1;
    d.lsel     = 2'd0;
    unique case (op)
      OP_ADD: ;
      OP_ADC: d.use_cin = 1'b1;
      OP_SUB: d.do_sub = 1'b1;
      OP_SBC: begin d.do_sub = 1'b1; d.use_cin = 1'b1; end
      OP_AND: begin d.is_logic = 1'b1; d.lsel = 2'd0; end
      OP_XOR: begin d.is_logic = 1'b1; d.lsel = 2'd1; end
      OP_OR:  begin d.is_logic = 1'b1; d.lsel = 2'd2; end
      OP_CMP: begin d.do_sub = 1'b1; d.wr_acc = 1'b0; end
      default: ;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         use_cin,
  input  logic         do_sub,
  output logic [W-1:0] r,
  output logic         cy,
  output logic         ovf
);
  localparam int EW = W + 1;
  localparam int MSB = W - 1;

  logic [EW-1:0] ext;
  logic          ci;

  always_comb begin
    ci = use_cin & cin;
    if (do_sub)
      ext = {1'b0, a} - {1'b0, b} - EW'(ci);
    else
      ext = {1'b0, a} + {1'b0, b} + EW'(ci);
  end

  assign r  = ext[W-1:0];
  assign cy = ext[W];

  always_comb begin
    if (do_sub)
      ovf = (a[MSB] != b[MSB]) && (r[MSB] != a[MSB]);
    else
      ovf = (a[MSB] == b[MSB]) && (r[MSB] != a[MSB]);
  end

  AST_OVF_FLIPS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (r[MSB] != a[MSB])); // R6
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] r,
  output logic         hi_any
);
  localparam int HW = W / 2;

  always_comb begin
    unique case (sel)
      2'd0:    r = a & b;
      2'd1:    r = a ^ b;
      2'd2:    r = a | b;
      default: r = '0;
    endcase
  end

  logic [HW-1:0] hi_bits;
  generate
    for (genvar i = 0; i < HW; i++) begin : g_hi
      assign hi_bits[i] = r[W-HW+i];
    end
  endgenerate
  assign hi_any = |hi_bits;
endmodule

// File: rtl/acc_alu_flagbank.sv
module acc_alu_flagbank #(
  parameter int FW = 4,
  parameter int NB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             bank_sel,
  input  logic [FW-1:0]    d,
  output logic [NB*FW-1:0] q_flat
);
  localparam int SW = (NB > 1) ? $clog2(NB) : 1;

  generate
    for (genvar k = 0; k < NB; k++) begin : g_bank
      logic [FW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (we && (SW'(bank_sel) == SW'(k)))
          q <= d;
      end
      assign q_flat[k*FW +: FW] = q;
    end
  endgenerate

  AST_PRI_TAKES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !bank_sel) |=> (q_flat[FW-1:0] == $past(d))); // R9
  AST_PRI_HOLDS_ON_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bank_sel) |=> $stable(q_flat[FW-1:0])); // R9
  AST_ALT_HOLDS_ON_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !bank_sel) |=> $stable(q_flat[2*FW-1:FW])); // R9
  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q_flat)); // R9
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         cin_i,
  input  logic [2:0]   op_i,
  input  logic         flag_we_i,
  input  logic         alt_sel_i,
  output logic [W-1:0] res_o,
  output logic         acc_we_o,
  output logic [3:0]   nflags_o,
  output logic [3:0]   pri_flags_o,
  output logic [3:0]   alt_flags_o
);
  localparam int NBANK = 2;

  alu_op_e op;
  dec_t    dec;
  assign op  = alu_op_e'(op_i);
  assign dec = decode_op(op);

  logic [W-1:0] ar_r, lg_r;
  logic         ar_cy, ar_ovf, lg_hi;

  acc_alu_arith #(.W(W)) u_arith (
    .clk(clk), .rst_n(rst_n),
    .a(acc_i), .b(opnd_i), .cin(cin_i),
    .use_cin(dec.use_cin), .do_sub(dec.do_sub),
    .r(ar_r), .cy(ar_cy), .ovf(ar_ovf)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .a(acc_i), .b(opnd_i), .sel(dec.lsel),
    .r(lg_r), .hi_any(lg_hi)
  );

  flags_t nf;
  always_comb begin
    res_o  = dec.is_logic ? lg_r : ar_r;
    nf.sgn = res_o[W-1];
    nf.zer = (res_o == '0);
    nf.lv  = dec.is_logic ? lg_hi : ar_ovf;
    nf.cy  = dec.is_logic ? 1'b0 : ar_cy;
  end

  assign nflags_o = nf;
  assign acc_we_o = dec.wr_acc;

  logic [NBANK*FLAG_W-1:0] banks;
  acc_alu_flagbank #(.FW(FLAG_W), .NB(NBANK)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .we(flag_we_i), .bank_sel(alt_sel_i),
    .d(nflags_o), .q_flat(banks)
  );

  assign pri_flags_o = banks[FLAG_W-1:0];
  assign alt_flags_o = banks[2*FLAG_W-1:FLAG_W];

  AST_LOGIC_CY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[2] && (op_i != 3'd7)) |-> !nflags_o[0]); // R5
  AST_CMP_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd7) |-> !acc_we_o); // R4
  AST_ZERO_NO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    nflags_o[2] |-> !nflags_o[3]); // R8
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic       cin_i = 1'b0;
  logic [2:0] op_i = '0;
  logic       flag_we_i = 1'b0, alt_sel_i = 1'b0;
  logic [7:0] res_o;
  logic       acc_we_o;
  logic [3:0] nflags_o, pri_flags_o, alt_flags_o;

  always #5 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .opnd_i(opnd_i),
    .cin_i(cin_i), .op_i(op_i), .flag_we_i(flag_we_i), .alt_sel_i(alt_sel_i),
    .res_o(res_o), .acc_we_o(acc_we_o), .nflags_o(nflags_o),
    .pri_flags_o(pri_flags_o), .alt_flags_o(alt_flags_o)
  );

  typedef struct {
    logic [7:0] res;
    logic       we;
    logic [3:0] nf;
    logic [3:0] pri;
    logic [3:0] alt;
    string      tag;
  } item_t;

  item_t      sb[$];
  int         nchk = 0, nfail = 0;
  logic [3:0] m_pri = '0, m_alt = '0;
  bit         done = 0;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic ci, input logic fwe, input logic alt, input string tag);
    item_t it;
    logic [8:0] e;
    logic [7:0] r;
    logic c, v, bi;
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = b; cin_i = ci; flag_we_i = fwe; alt_sel_i = alt;
    c = 1'b0; v = 1'b0;
    bi = (op == 3'd1 || op == 3'd3) ? ci : 1'b0;
    case (op)
      3'd0, 3'd1: begin
        e = {1'b0, a} + {1'b0, b} + {8'd0, bi};
        r = e[7:0]; c = e[8];
        v = (a[7] == b[7]) && (r[7] != a[7]);
      end
      3'd2, 3'd3, 3'd7: begin
        e = {1'b0, a} - {1'b0, b} - {8'd0, bi};
        r = e[7:0]; c = e[8];
        v = (a[7] != b[7]) && (r[7] != a[7]);
      end
      3'd4: begin r = a & b; v = |r[7:4]; end
      3'd5: begin r = a ^ b; v = |r[7:4]; end
      default: begin r = a | b; v = |r[7:4]; end
    endcase
    it.res = r;
    it.we  = (op != 3'd7);
    it.nf  = {r[7], (r == 8'd0), v, c};
    if (fwe && !alt) m_pri = it.nf;
    if (fwe && alt)  m_alt = it.nf;
    it.pri = m_pri;
    it.alt = m_alt;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares one cycle's outputs just after the capturing edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, "res", res_o, it.res);
      chk(it.tag, "acc_we R4", {7'd0, acc_we_o}, {7'd0, it.we});
      chk(it.tag, "nflags R8", {4'd0, nflags_o}, {4'd0, it.nf});
      chk(it.tag, "pri R9", {4'd0, pri_flags_o}, {4'd0, it.pri});
      chk(it.tag, "alt R9", {4'd0, alt_flags_o}, {4'd0, it.alt});
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          nfail++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    logic [7:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "pri after reset", {4'd0, pri_flags_o}, 8'd0);
    chk("R10", "alt after reset", {4'd0, alt_flags_o}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "pri held", {4'd0, pri_flags_o}, 8'd0);

    do_op(3'd0, 8'h7F, 8'h01, 1'b1, 1'b1, 1'b0, "R1 R6 add overflow");
    do_op(3'd0, 8'h80, 8'h80, 1'b0, 1'b1, 1'b1, "R1 R6 carry+overflow");
    do_op(3'd1, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, "R2 adc wrap zero");
    do_op(3'd1, 8'h12, 8'h34, 1'b0, 1'b1, 1'b1, "R2 adc no carry-in");
    do_op(3'd2, 8'h05, 8'h05, 1'b1, 1'b1, 1'b0, "R3 sub equal");
    do_op(3'd2, 8'h00, 8'h01, 1'b0, 1'b1, 1'b1, "R3 sub borrow");
    do_op(3'd2, 8'h80, 8'h01, 1'b0, 1'b1, 1'b0, "R3 R6 sub overflow");
    do_op(3'd3, 8'h10, 8'h0F, 1'b1, 1'b1, 1'b1, "R3 sbc borrow-in");
    do_op(3'd7, 8'h33, 8'h44, 1'b0, 1'b1, 1'b1, "R4 cmp alt bank");
    do_op(3'd7, 8'h44, 8'h44, 1'b1, 1'b1, 1'b0, "R4 cmp equal");
    do_op(3'd4, 8'hF0, 8'h0F, 1'b1, 1'b1, 1'b0, "R5 R7 and zero");
    do_op(3'd5, 8'h0F, 8'hFF, 1'b1, 1'b1, 1'b1, "R5 R7 xor upper set");
    do_op(3'd6, 8'h01, 8'h02, 1'b1, 1'b1, 1'b0, "R5 R7 or low only");
    do_op(3'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, "R9 no write hold");
    do_op(3'd6, 8'h80, 8'h00, 1'b0, 1'b0, 1'b1, "R9 no write alt");

    lf = 8'hA5;
    for (int i = 0; i < 48; i++) begin
      logic [7:0] a2;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      a2 = lf ^ 8'h3C;
      do_op(lf[2:0], a2, {lf[3:0], lf[7:4]}, lf[5], lf[6], lf[1], "R1 R2 R3 R8 R9 mix");
    end

    @(negedge clk);
    flag_we_i = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule